// File: doc/BRIEF.md
# Clock-Calendar Register Front End

This block is the register side of a serial-bus real-time clock. It sits behind a slave byte engine that has already decoded the bus protocol. That engine reports three kinds of event: a start that opens a write, a start that opens a read, and a stop. It also passes in each received byte and raises a request whenever the master wants a byte back. The block keeps a byte pointer into a 64-byte register space and holds a frozen copy of the seven time-of-day bytes. It also manages a region of general-purpose storage that keeps its contents. When software writes a time byte, the block hands the updated time image to an external timekeeping counter with a one-cycle load strobe. The live time comes back in as a packed BCD word.

Three parameters set the layout. The first is the point where the auto-incrementing pointer wraps. The second is the first address of the general-purpose storage. The third says whether the month byte carries a century flag. A fourth parameter adds the control byte at address 7.

The transfer sequencer has four states:
- IDLE, the reset state and the state after a stop.
- GET_PTR, entered on a write start. The next byte becomes the pointer, and the sequencer moves to WRITING.
- WRITING, where each byte is a register write.
- READING, entered on a read start, where each request returns one byte.

A write start moves to GET_PTR and a read start moves to READING from any state. A stop returns to IDLE from any state.

Top module: `rtc_regif`

## Requirements
- R1: In GET_PTR, the first received byte sets the pointer to that byte modulo 64 (its low six bits) and is not stored; every later byte in the same write transaction is a register write.
- R2: Each serviced read or write advances the pointer by one; when the incremented value reaches REG_SIZE the pointer becomes 0.
- R3: Every start condition copies the live time into bytes 0..6 with unused bits cleared. The masks are 0x7F for seconds and minutes, 0x3F for hours in 24-hour mode, 0x07 for weekday, 0x3F for date, 0x1F for month and 0xFF for year.
- R4: A pointer wrap to 0 also re-takes the time copy, so the byte read right after a wrap reflects the live time at that moment.
- R5: A write to addresses 0..6 stores the byte, and one cycle later `ld_valid` pulses for one cycle. At the same time `ld_time` shows the seven time bytes with the new byte substituted (byte n in bits 8n+7..8n).
- R6: Bytes written at or above NV_START are stored and read back unchanged.
- R7: Writes to addresses above 6 and below NV_START (except the control byte) are ignored, and such addresses read as 0.
- R8: With HAS_CTRL set, address 7 keeps only bits 7, 5, 4, 1 and 0; bits 2, 3 and 6 always read 0. Bit 5 is set by `osc_fault`, is cleared by writing 0 and is unchanged by writing 1.
- R9: A read start leaves the pointer where the previous transaction left it.
- R10: When bit 6 of the hour byte is 1, the time copy formats the hour as 12-hour BCD 1..12 with bit 5 as the PM flag and keeps bit 6 set. When bit 6 is 0, the hour is 24-hour BCD.
- R11: With HAS_CENTURY set, bit 7 of the month byte copies `live_century`; without it, bit 7 is 0.
- R12: Reset clears all registers, sets the pointer to 0 and enters IDLE. `rd_valid` and `ld_valid` are 0 out of reset.
- R13: Read requests are serviced only in READING, where `rd_data` and a `rd_valid` pulse appear one cycle after the request. Received bytes are taken only in GET_PTR and WRITING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Start condition opening a write transfer |
| start_rd | input | 1 | Start condition opening a read transfer |
| stop | input | 1 | Stop condition |
| wr_valid | input | 1 | A received byte is present on wr_data |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Master requests one byte |
| rd_data | output | 8 | Returned byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| live_time | input | 56 | Live time in BCD, seconds in bits 7..0 up to year in bits 55..48, hour in 24-hour form |
| live_century | input | 1 | Live century flag |
| osc_fault | input | 1 | Oscillator stop detected; sets the control flag |
| ld_valid | output | 1 | Load strobe to the timekeeping counter |
| ld_time | output | 56 | Time image to load, same byte order as live_time |

## Verification
The assertions assume that the byte engine raises at most one event or byte strobe per cycle. They also assume that a start, a stop and a data strobe never share a cycle, since the sequencer resolves such overlaps by priority, not by protocol. The bench keeps to this by driving each event or byte for exactly one cycle in its own slot. It runs two variants side by side: a 64-byte space with the control byte, and a 13-byte space with a century flag and no storage region. It changes the live time between a read start and a wrap, so the copy taken on the wrap can be told apart from the one taken on the start.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;

    localparam int SPACE_BYTES = 64;
    localparam int ADDR_W      = 6;
    localparam int TIME_BYTES  = 7;
    localparam int CTRL_ADDR   = 7;
    localparam int HOUR_ADDR   = 2;
    localparam int OSF_BIT     = 5;
    localparam int MODE12_BIT  = 6;

    // bits of the control byte that can be written directly
    localparam logic [7:0] CTRL_RW_MASK = 8'h93;
    localparam logic [7:0] CTRL_OSF     = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GET_PTR,
        ST_WRITING,
        ST_READING
    } xfer_state_e;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(int'(b[7:4]) * 10 + int'(b[3:0]));
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        int tens;
        int ones;
        tens = int'(v) / 10;
        ones = int'(v) % 10;
        return {4'(tens), 4'(ones)};
    endfunction

endpackage

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_regif_pkg::*;
#(
    parameter int REG_SIZE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              stop,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output xfer_state_e       state,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              relatch
);

    localparam logic [ADDR_W:0] WRAP_AT = (ADDR_W+1)'(REG_SIZE);

    xfer_state_e       state_d;
    logic [ADDR_W-1:0] ptr_d;
    logic              take_ptr;
    logic              advance;
    logic              wrap;
    logic              any_start;
    logic              unused_fsm;

    assign unused_fsm = ^wr_data[7:ADDR_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
        end else begin
            state <= state_d;
            ptr   <= ptr_d;
        end
    end

    // next state and pointer
    always_comb begin
        state_d = state;
        if (start_wr) begin
            state_d = ST_GET_PTR;
        end else if (start_rd) begin
            state_d = ST_READING;
        end else if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_d = ST_IDLE;
                ST_GET_PTR: state_d = wr_valid ? ST_WRITING : ST_GET_PTR;
                ST_WRITING: state_d = ST_WRITING;
                ST_READING: state_d = ST_READING;
                default:    state_d = ST_IDLE;
            endcase
        end

        ptr_d = ptr;
        if (take_ptr) begin
            ptr_d = wr_data[ADDR_W-1:0];
        end else if (advance) begin
            ptr_d = wrap ? '0 : ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        any_start = start_wr | start_rd;
        take_ptr  = 1'b0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        if (!any_start && !stop) begin
            unique case (state)
                ST_IDLE:    ;
                ST_GET_PTR: take_ptr = wr_valid;
                ST_WRITING: wr_en    = wr_valid;
                ST_READING: rd_en    = rd_req;
                default:    ;
            endcase
        end
        advance = wr_en | rd_en;
        wrap    = advance && (({1'b0, ptr} + 1'b1) >= WRAP_AT);
        relatch = any_start | wrap;
    end

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_regif_pkg::*;
#(
    parameter bit HAS_CENTURY = 1'b0
) (
    input  logic [8*TIME_BYTES-1:0] live_time,
    input  logic                    live_century,
    input  logic                    hour12_sel,
    output logic [8*TIME_BYTES-1:0] snap_time
);

    logic [6:0] h24;
    logic [6:0] h12;
    logic       pm;
    logic [7:0] hr_bcd;
    logic       cent;
    logic       unused_snap;

    assign cent = HAS_CENTURY ? live_century : 1'b0;

    always_comb begin
        h24    = bcd_to_bin({2'b00, live_time[21:16]});
        pm     = (h24 >= 7'd12);
        if (h24 == 7'd0) begin
            h12 = 7'd12;
        end else if (h24 > 7'd12) begin
            h12 = h24 - 7'd12;
        end else begin
            h12 = h24;
        end
        hr_bcd = bin_to_bcd(h12);

        snap_time[7:0]   = {1'b0, live_time[6:0]};
        snap_time[15:8]  = {1'b0, live_time[14:8]};
        snap_time[23:16] = hour12_sel ? {2'b01, pm, hr_bcd[4:0]}
                                      : {2'b00, live_time[21:16]};
        snap_time[31:24] = {5'b0, live_time[26:24]};
        snap_time[39:32] = {2'b0, live_time[37:32]};
        snap_time[47:40] = {cent, 2'b0, live_time[44:40]};
        snap_time[55:48] = live_time[55:48];
    end

    assign unused_snap = ^{live_time[7], live_time[15], live_time[23:22],
                           live_time[31:27], live_time[39:38], live_time[47:45],
                           hr_bcd[7:5], live_century};

endmodule

// File: rtl/rtc_reg_store.sv
module rtc_reg_store
    import rtc_regif_pkg::*;
#(
    parameter int NV_START = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wr_data,
    input  logic                    relatch,
    input  logic [8*TIME_BYTES-1:0] snap_time,
    input  logic                    osc_fault,
    output logic [7:0]              rd_data,
    output logic                    rd_valid,
    output logic                    ld_valid,
    output logic [8*TIME_BYTES-1:0] ld_time,
    output logic                    hour12_sel
);

    logic [SPACE_BYTES-1:0][7:0] cell_q;
    logic [8*TIME_BYTES-1:0]     ld_img;
    logic                        time_hit;

    for (genvar a = 0; a < SPACE_BYTES; a++) begin : g_cell
        logic hit;
        assign hit = wr_en && (addr == ADDR_W'(a));

        if (a < TIME_BYTES) begin : g_time
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (relatch) begin
                    q <= snap_time[8*a +: 8];
                end else if (hit) begin
                    q <= wr_data;
                end
            end
            assign cell_q[a] = q;
        end else if (HAS_CTRL && a == CTRL_ADDR) begin : g_ctrl
            logic [7:0] q;
            logic [7:0] d;
            always_comb begin
                d = q;
                if (hit) begin
                    d = (wr_data & CTRL_RW_MASK) | (wr_data & q & CTRL_OSF);
                end
                if (osc_fault) begin
                    d[OSF_BIT] = 1'b1;
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
            assign cell_q[a] = q;
        end else if (a >= NV_START) begin : g_ram
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (hit) begin
                    q <= wr_data;
                end
            end
            assign cell_q[a] = q;
        end else begin : g_hole
            assign cell_q[a] = '0;
        end
    end

    always_comb begin
        for (int i = 0; i < TIME_BYTES; i++) begin
            ld_img[8*i +: 8] = (wr_en && addr == ADDR_W'(i)) ? wr_data : cell_q[i];
        end
        time_hit = wr_en && (addr < ADDR_W'(TIME_BYTES));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            ld_valid <= 1'b0;
            ld_time  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= cell_q[addr];
            end
            ld_valid <= time_hit;
            if (time_hit) begin
                ld_time <= ld_img;
            end
        end
    end

    assign hour12_sel = cell_q[HOUR_ADDR][MODE12_BIT];

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
    import rtc_regif_pkg::*;
#(
    parameter int REG_SIZE    = 64,
    parameter int NV_START    = 8,
    parameter bit HAS_CENTURY = 1'b0,
    parameter bit HAS_CTRL    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_wr,
    input  logic        start_rd,
    input  logic        stop,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        rd_req,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic [55:0] live_time,
    input  logic        live_century,
    input  logic        osc_fault,
    output logic        ld_valid,
    output logic [55:0] ld_time
);

    xfer_state_e             state;
    logic [ADDR_W-1:0]       ptr;
    logic                    wr_en;
    logic                    rd_en;
    logic                    relatch;
    logic                    hour12_sel;
    logic [8*TIME_BYTES-1:0] snap_time;

    rtc_xfer_fsm #(.REG_SIZE(REG_SIZE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .stop     (stop),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .state    (state),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .relatch  (relatch)
    );

    rtc_snapshot #(.HAS_CENTURY(HAS_CENTURY)) u_snap (
        .live_time    (live_time),
        .live_century (live_century),
        .hour12_sel   (hour12_sel),
        .snap_time    (snap_time)
    );

    rtc_reg_store #(.NV_START(NV_START), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (ptr),
        .wr_data    (wr_data),
        .relatch    (relatch),
        .snap_time  (snap_time),
        .osc_fault  (osc_fault),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .ld_valid   (ld_valid),
        .ld_time    (ld_time),
        .hour12_sel (hour12_sel)
    );

endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk
    import rtc_regif_pkg::*;
#(
    parameter int REG_SIZE = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_wr,
    input logic              start_rd,
    input logic              stop,
    input logic              wr_valid,
    input logic [7:0]        wr_data,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              ld_valid,
    input xfer_state_e       state,
    input logic [ADDR_W-1:0] ptr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              hour12_sel
);

    a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GET_PTR && wr_valid && !start_wr && !start_rd && !stop)
        |=> (ptr == $past(wr_data[ADDR_W-1:0])));

    a_r2_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |=> (int'(ptr) < REG_SIZE));

    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && int'(ptr) == REG_SIZE - 1) |=> (ptr == '0));

    a_r5_load_after_time_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(ptr) < TIME_BYTES) |=> ld_valid);

    a_r5_load_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(wr_en));

    a_r9_read_start_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && !start_wr) |=> (ptr == $past(ptr)));

    a_r10_mode_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hour12_sel) |-> $past(wr_en && int'(ptr) == HOUR_ADDR));

    a_r13_read_in_read_state: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(state == ST_READING && rd_req));

endmodule

bind rtc_regif rtc_regif_chk #(.REG_SIZE(REG_SIZE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr   (start_wr),
    .start_rd   (start_rd),
    .stop       (stop),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .ld_valid   (ld_valid),
    .state      (state),
    .ptr        (ptr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .hour12_sel (hour12_sel)
);

// File: tb/rtc_regif_tb.sv
module rtc_regif_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_wr, start_rd, stop, wr_valid, rd_req, osc_fault, live_century;
    logic [7:0]  wr_data;
    logic [55:0] live_time;
    logic [7:0]  rd_data, rd_data_b;
    logic        rd_valid, rd_valid_b, ld_valid, ld_valid_b;
    logic [55:0] ld_time, ld_time_b;

    int checks = 0;
    int errors = 0;

    // year, month, date, weekday, hour, minute, second (junk in unused bits)
    localparam logic [55:0] L1 = {8'h47, 8'hF2, 8'hD8, 8'hFB, 8'hE3, 8'hB7, 8'hD9};
    localparam logic [55:0] L2 = {8'h99, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h05};

    always #5 clk = ~clk;

    rtc_regif u_dut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd), .stop(stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .live_time(live_time), .live_century(live_century),
        .osc_fault(osc_fault), .ld_valid(ld_valid), .ld_time(ld_time)
    );

    rtc_regif #(.REG_SIZE(13), .NV_START(13), .HAS_CENTURY(1'b1), .HAS_CTRL(1'b0)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd), .stop(stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data_b),
        .rd_valid(rd_valid_b), .live_time(live_time), .live_century(live_century),
        .osc_fault(osc_fault), .ld_valid(ld_valid_b), .ld_time(ld_time_b)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ev_wr();
        start_wr = 1'b1; step(); start_wr = 1'b0;
    endtask

    task automatic ev_rd();
        start_rd = 1'b1; step(); start_rd = 1'b0;
    endtask

    task automatic ev_stop();
        stop = 1'b1; step(); stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        wr_valid = 1'b1; wr_data = b; step(); wr_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] a, output logic [7:0] b);
        rd_req = 1'b1; step(); rd_req = 1'b0;
        a = rd_data;
        b = rd_data_b;
        chk("R13 rd_valid pulse after request", 64'(rd_valid), 64'd1);
    endtask

    task automatic write_reg(input logic [7:0] adr, input logic [7:0] val);
        ev_wr(); send(adr); send(val); ev_stop();
    endtask

    task automatic read_reg(input logic [7:0] adr, output logic [7:0] a, output logic [7:0] b);
        ev_wr(); send(adr); ev_rd(); get(a, b); ev_stop();
    endtask

    task automatic t_reset();
        logic [7:0] a, b;
        chk("R12 rd_valid after reset", 64'(rd_valid), 64'd0);
        chk("R12 ld_valid after reset", 64'(ld_valid), 64'd0);
        live_time = L1;
        ev_rd();
        get(a, b); chk("R12 pointer 0 / R3 seconds", 64'(a), 64'h59);
        get(a, b); chk("R3 minutes", 64'(a), 64'h37);
        get(a, b); chk("R3 hours 24h", 64'(a), 64'h23);
        get(a, b); chk("R3 weekday", 64'(a), 64'h03);
        get(a, b); chk("R3 date", 64'(a), 64'h18);
        get(a, b); chk("R11 month no century", 64'(a), 64'h12);
                   chk("R11 month with century", 64'(b), 64'h92);
        get(a, b); chk("R3 year", 64'(a), 64'h47);
        get(a, b); chk("R12 control byte cleared", 64'(a), 64'h00);
        get(a, b); chk("R12 storage cleared", 64'(a), 64'h00);
        ev_stop();
    endtask

    task automatic t_ram();
        logic [7:0] a, b;
        ev_wr(); send(8'h10); send(8'hAA); send(8'h55); ev_stop();
        ev_wr(); send(8'h10); ev_rd();
        get(a, b); chk("R6 storage byte 0x10 / R9 read start keeps pointer", 64'(a), 64'hAA);
        get(a, b); chk("R2 R6 storage byte 0x11", 64'(a), 64'h55);
        ev_stop();
    endtask

    task automatic t_ptr_mod();
        logic [7:0] a, b;
        write_reg(8'h52, 8'h3C);
        read_reg(8'h12, a, b);
        chk("R1 pointer byte taken modulo 64", 64'(a), 64'h3C);
        read_reg(8'h11, a, b);
        chk("R1 pointer byte not stored", 64'(a), 64'h55);
    endtask

    task automatic t_time_load();
        live_time = L1;
        ev_wr(); send(8'h04); send(8'h21);
        chk("R5 load strobe", 64'(ld_valid), 64'd1);
        chk("R5 load image date", 64'(ld_time), 64'({8'h47, 8'h12, 8'h21, 8'h03, 8'h23, 8'h37, 8'h59}));
        send(8'h11);
        chk("R5 load image month, date kept", 64'(ld_time), 64'({8'h47, 8'h11, 8'h21, 8'h03, 8'h23, 8'h37, 8'h59}));
        step();
        chk("R5 load strobe one cycle", 64'(ld_valid), 64'd0);
        ev_stop();
    endtask

    task automatic t_hole();
        logic [7:0] a, b;
        write_reg(8'h09, 8'h77);
        read_reg(8'h09, a, b);
        chk("R7 hole write ignored", 64'(b), 64'h00);
        chk("R6 storage at 0x09", 64'(a), 64'h77);
    endtask

    task automatic t_ctrl();
        logic [7:0] a, b;
        write_reg(8'h07, 8'hFF);
        read_reg(8'h07, a, b);
        chk("R8 reserved bits zero, flag not set by 1", 64'(a), 64'h93);
        osc_fault = 1'b1; step(); osc_fault = 1'b0;
        read_reg(8'h07, a, b);
        chk("R8 flag set by fault", 64'(a), 64'hB3);
        write_reg(8'h07, 8'hFF);
        read_reg(8'h07, a, b);
        chk("R8 writing 1 keeps flag", 64'(a), 64'hB3);
        write_reg(8'h07, 8'h00);
        read_reg(8'h07, a, b);
        chk("R8 writing 0 clears flag", 64'(a), 64'h00);
    endtask

    task automatic t_wrap_full();
        logic [7:0] a, b;
        live_time = L1;
        ev_wr(); send(8'h3F); ev_rd();
        live_time = L2;
        get(a, b); chk("R2 last byte of 64", 64'(a), 64'h00);
        get(a, b); chk("R4 wrap at 64 re-latches seconds", 64'(a), 64'h05);
        get(a, b); chk("R4 wrap at 64 re-latches minutes", 64'(a), 64'h00);
        ev_stop();
    endtask

    task automatic t_wrap_short();
        logic [7:0] a, b;
        live_time = L1;
        ev_wr(); send(8'h0C); ev_rd();
        live_time = L2;
        get(a, b); chk("R7 hole read at 0x0C", 64'(b), 64'h00);
        get(a, b); chk("R2 R4 wrap at 13 re-latches seconds", 64'(b), 64'h05);
        get(a, b); chk("R4 wrap at 13 minutes", 64'(b), 64'h00);
        ev_stop();
    endtask

    task automatic t_hour12();
        logic [7:0] a, b;
        write_reg(8'h02, 8'h40);
        live_time = L1;
        read_reg(8'h02, a, b); chk("R10 23h as 11 PM", 64'(a), 64'h71);
        live_time = {L1[55:24], 8'h00, L1[15:0]};
        read_reg(8'h02, a, b); chk("R10 0h as 12 AM", 64'(a), 64'h52);
        live_time = {L1[55:24], 8'h15, L1[15:0]};
        read_reg(8'h02, a, b); chk("R10 15h as 3 PM", 64'(a), 64'h63);
        live_time = {L1[55:24], 8'h12, L1[15:0]};
        read_reg(8'h02, a, b); chk("R10 12h as 12 PM", 64'(a), 64'h72);
        write_reg(8'h02, 8'h00);
        live_time = {L1[55:24], 8'h15, L1[15:0]};
        read_reg(8'h02, a, b); chk("R10 back to 24h", 64'(a), 64'h15);
    endtask

    task automatic t_ignored();
        logic [7:0] a, b;
        rd_req = 1'b1; step(); rd_req = 1'b0;
        chk("R13 read request in idle ignored", 64'(rd_valid), 64'd0);
        ev_wr(); send(8'h20); send(8'h11); send(8'h44); ev_stop();
        ev_wr(); send(8'h21);
        rd_req = 1'b1; step(); rd_req = 1'b0;
        chk("R13 read request while writing ignored", 64'(rd_valid), 64'd0);
        ev_rd();
        send(8'h99);
        get(a, b); chk("R13 byte during read ignored", 64'(a), 64'h44);
        ev_stop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_wr = 1'b0; start_rd = 1'b0; stop = 1'b0;
        wr_valid = 1'b0; wr_data = '0; rd_req = 1'b0; osc_fault = 1'b0;
        live_century = 1'b1; live_time = L1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ram();
        t_ptr_mod();
        t_time_load();
        t_hole();
        t_ctrl();
        t_wrap_full();
        t_wrap_short();
        t_hour12();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule